// File: doc/BRIEF.md
# Wide-Word Pixel Fetcher with Byte-Lane Host Writes

This block connects a video memory whose data word holds several pixels to a display pipeline that consumes one pixel per clock, and to a narrow host port that reads and writes single pixels. The display side fetches one whole word per memory access, then hands out its pixels one per clock, starting with the least significant byte. The next word is read just early enough that the pixel stream has no gaps. Every clock in which no video fetch is due is offered to the host.

A display line begins with a one-cycle start pulse that carries the first word address and the number of words in the line. Host writes reach memory in one of two ways, chosen by a parameter. In the first, a single write cycle asserts only the byte enable of the addressed lane. In the second, the block reads the whole word, replaces one byte and writes the word back with all enables set.

The memory is synchronous, with one cycle of read latency. It is outside the block, as is sync generation.

Top module: `wide_pix_fetch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pix_valid`, `host_gnt`, `host_rvalid` and `mem_en` are low.
- R2: An accepted `vid_start` reads word `vid_base` in the same cycle (`mem_en`=1, `mem_we`=0, `mem_addr`=`vid_base`). `pix_valid` first goes high two cycles later.
- R3: The pixels of a word appear lowest lane first: pixel k comes from data bits [8k+7:8k]. Words follow in ascending address order.
- R4: After a start, `pix_valid` stays high for exactly `vid_words`×PIX_PER_WORD consecutive cycles and then falls. There is no gap between words.
- R5: Each later word is read in the cycle that shows lane PIX_PER_WORD-2 of the word before it. No read follows the last word. The other PIX_PER_WORD-1 cycles of each word are free for the host.
- R6: A video fetch has priority. The host is never granted in a fetch cycle and waits for the next free cycle.
- R7: In byte-select mode (RMW_WRITE=0), a write is granted in the first free cycle as one memory write. The write asserts only the `mem_be` bit of lane `host_addr[1:0]` and carries the byte in that lane. The word address is `host_addr[9:2]`. Other bytes keep their values.
- R8: In read-modify-write mode (RMW_WRITE=1), a write first reads the word and then writes the merged word with all `mem_be` bits set. `host_gnt` comes only with the write, two cycles after the request when video is idle. Other bytes keep their values.
- R9: A host read (`host_we`=0) is granted in the cycle it reads memory. In the next cycle `host_rvalid` is high and `host_rdata` holds the addressed byte.
- R10: `vid_start` is ignored while a line is in progress and when `vid_words` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pixel per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_start | input | 1 | Start a display line |
| vid_base | input | 8 | First word address of the line |
| vid_words | input | 8 | Words in the line |
| pix_valid | output | 1 | Pixel output valid |
| pix_data | output | 8 | Current pixel |
| host_req | input | 1 | Host access request, held until granted |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Byte address {word, lane} |
| host_wdata | input | 8 | Write byte |
| host_gnt | output | 1 | Access accepted this cycle |
| host_rvalid | output | 1 | Read byte valid |
| host_rdata | output | 8 | Read byte |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 8 | Memory word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |

## Verification
A wrong lane counter shows up in the first word: pixels come out of order, or the read of the next word lands on the wrong lane. The bench checks the fetch cycle at every pixel, so such a fault is caught within four cycles of the first pixel. A lost pending-word flag ends the line early or stretches it, and this shows in the cycle `pix_valid` should change. A wrong lane-select or merge state corrupts a neighbouring byte. That is seen on the first read-back of the word that was written.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
   // host write sequencer states
   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_CAP  = 2'd1,
      HS_WR   = 2'd2
   } host_st_e;
endpackage

// File: rtl/pxf_vid_seq.sv
module pxf_vid_seq #(
   parameter int PPW     = 4,
   parameter int WADDR_W = 8,
   parameter int LEN_W   = 8,
   parameter int LANE_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WADDR_W-1:0] base,
   input  logic [LEN_W-1:0]   words,
   output logic               fetch,
   output logic [WADDR_W-1:0] fetch_addr,
   output logic               load,
   output logic               active,
   output logic [LANE_W-1:0]  phase
);
   localparam logic [LANE_W-1:0] PH_FETCH = LANE_W'(PPW - 2);
   localparam logic [LANE_W-1:0] PH_LAST  = LANE_W'(PPW - 1);

   logic               act_q, prime_q, more_q;
   logic [LANE_W-1:0]  ph_q;
   logic [LEN_W-1:0]   left_q;
   logic [WADDR_W-1:0] next_q;
   logic               start_ok, mid_fetch;

   assign start_ok   = start && !act_q && !prime_q && (words != '0);
   assign mid_fetch  = act_q && (ph_q == PH_FETCH) && (left_q != '0);
   assign fetch      = start_ok || mid_fetch;
   assign fetch_addr = start_ok ? base : next_q;
   assign load       = prime_q || (act_q && (ph_q == PH_LAST) && more_q);
   assign active     = act_q;
   assign phase      = ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         prime_q <= 1'b0;
         more_q  <= 1'b0;
         ph_q    <= '0;
         left_q  <= '0;
         next_q  <= '0;
      end else begin
         if (start_ok) begin
            prime_q <= 1'b1;
            next_q  <= base + 1'b1;
            left_q  <= words - 1'b1;
         end
         if (prime_q) begin
            prime_q <= 1'b0;
            act_q   <= 1'b1;
            ph_q    <= '0;
            more_q  <= 1'b0;
         end
         if (act_q) begin
            ph_q <= ph_q + 1'b1;
            if (mid_fetch) begin
               next_q <= next_q + 1'b1;
               left_q <= left_q - 1'b1;
               more_q <= 1'b1;
            end
            if (ph_q == PH_LAST) begin
               if (more_q) more_q <= 1'b0;
               else        act_q  <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/pxf_unpack.sv
module pxf_unpack #(
   parameter int PIX_W  = 8,
   parameter int PPW    = 4,
   parameter int LANE_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [PIX_W*PPW-1:0] word_in,
   input  logic [LANE_W-1:0]    phase,
   output logic [PIX_W-1:0]     pix
);
   logic [PIX_W*PPW-1:0] word_q;
   logic [PIX_W-1:0]     lane_w [PPW];

   always_ff @(posedge clk) begin
      if (!rst_n)    word_q <= '0;
      else if (load) word_q <= word_in;
   end

   for (genvar g = 0; g < PPW; g++) begin : g_lane
      assign lane_w[g] = word_q[g*PIX_W +: PIX_W];
   end

   assign pix = lane_w[phase];
endmodule

// File: rtl/pxf_host_port.sv
module pxf_host_port import pxf_pkg::*; #(
   parameter int PIX_W   = 8,
   parameter int PPW     = 4,
   parameter int WADDR_W = 8,
   parameter int LANE_W  = 2,
   parameter bit RMW     = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      slot_free,
   input  logic                      req,
   input  logic                      we,
   input  logic [WADDR_W+LANE_W-1:0] addr,
   input  logic [PIX_W-1:0]          wdata,
   input  logic [PIX_W*PPW-1:0]      mem_rdata,
   output logic                      go,
   output logic                      go_we,
   output logic [WADDR_W-1:0]        go_addr,
   output logic [PPW-1:0]            go_be,
   output logic [PIX_W*PPW-1:0]      go_wdata,
   output logic                      gnt,
   output logic                      rvalid,
   output logic [PIX_W-1:0]          rdata
);
   localparam int DATA_W = PIX_W * PPW;
   localparam logic [PPW-1:0] BE_ONE = PPW'(1);

   host_st_e          st_q, st_d;
   logic [LANE_W-1:0] lane, lane_q;
   logic              rd_pend_q;
   logic [DATA_W-1:0] wr_word;
   logic [PIX_W-1:0]  rd_lane [PPW];

   assign lane    = addr[LANE_W-1:0];
   assign go_addr = addr[WADDR_W+LANE_W-1:LANE_W];

   if (RMW) begin : g_rmw
      logic [DATA_W-1:0] merged, hold_q;
      for (genvar g = 0; g < PPW; g++) begin : g_mrg
         assign merged[g*PIX_W +: PIX_W] =
            (lane == LANE_W'(g)) ? wdata : mem_rdata[g*PIX_W +: PIX_W];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)               hold_q <= '0;
         else if (st_q == HS_CAP)  hold_q <= merged;
      end
      assign wr_word = hold_q;
   end else begin : g_bsel
      assign wr_word = {PPW{wdata}};
   end

   always_comb begin
      st_d     = st_q;
      go       = 1'b0;
      go_we    = 1'b0;
      go_be    = '0;
      go_wdata = wr_word;
      gnt      = 1'b0;
      case (st_q)
         HS_IDLE: begin
            if (req && slot_free) begin
               go = 1'b1;
               if (!we) begin
                  gnt = 1'b1;
               end else if (RMW) begin
                  st_d = HS_CAP;
               end else begin
                  go_we = 1'b1;
                  go_be = BE_ONE << lane;
                  gnt   = 1'b1;
               end
            end
         end
         HS_CAP: st_d = HS_WR;
         HS_WR: begin
            if (slot_free) begin
               go    = 1'b1;
               go_we = 1'b1;
               go_be = '1;
               gnt   = 1'b1;
               st_d  = HS_IDLE;
            end
         end
         default: st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= HS_IDLE;
         rd_pend_q <= 1'b0;
         lane_q    <= '0;
      end else begin
         st_q      <= st_d;
         rd_pend_q <= gnt && !we;
         if (gnt && !we) lane_q <= lane;
      end
   end

   for (genvar g = 0; g < PPW; g++) begin : g_rd
      assign rd_lane[g] = mem_rdata[g*PIX_W +: PIX_W];
   end

   assign rvalid = rd_pend_q;
   assign rdata  = rd_lane[lane_q];
endmodule

// File: rtl/wide_pix_fetch.sv
module wide_pix_fetch import pxf_pkg::*; #(
   parameter int PIX_W        = 8,
   parameter int PIX_PER_WORD = 4,
   parameter int WADDR_W      = 8,
   parameter int LEN_W        = 8,
   parameter bit RMW_WRITE    = 1'b0,
   localparam int DATA_W      = PIX_W * PIX_PER_WORD,
   localparam int LANE_W      = $clog2(PIX_PER_WORD),
   localparam int HADDR_W     = WADDR_W + LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vid_start,
   input  logic [WADDR_W-1:0] vid_base,
   input  logic [LEN_W-1:0]   vid_words,
   output logic               pix_valid,
   output logic [PIX_W-1:0]   pix_data,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [PIX_W-1:0]   host_wdata,
   output logic               host_gnt,
   output logic               host_rvalid,
   output logic [PIX_W-1:0]   host_rdata,
   output logic               mem_en,
   output logic               mem_we,
   output logic [WADDR_W-1:0] mem_addr,
   output logic [PIX_PER_WORD-1:0] mem_be,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata
);
   if (PIX_PER_WORD != 2 && PIX_PER_WORD != 4) begin : g_bad_ppw
      $error("PIX_PER_WORD must be 2 or 4");
   end
   if (PIX_W < 1 || WADDR_W < 1 || LEN_W < 1) begin : g_bad_w
      $error("widths must be positive");
   end

   logic                    vid_fetch, vid_load, vid_act;
   logic [WADDR_W-1:0]      vid_addr;
   logic [LANE_W-1:0]       phase;
   logic                    h_go, h_we;
   logic [WADDR_W-1:0]      h_addr;
   logic [PIX_PER_WORD-1:0] h_be;
   logic [DATA_W-1:0]       h_wdata;

   pxf_vid_seq #(
      .PPW(PIX_PER_WORD), .WADDR_W(WADDR_W), .LEN_W(LEN_W), .LANE_W(LANE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(vid_start), .base(vid_base),
      .words(vid_words), .fetch(vid_fetch), .fetch_addr(vid_addr),
      .load(vid_load), .active(vid_act), .phase(phase)
   );

   pxf_unpack #(
      .PIX_W(PIX_W), .PPW(PIX_PER_WORD), .LANE_W(LANE_W)
   ) u_unpack (
      .clk(clk), .rst_n(rst_n), .load(vid_load), .word_in(mem_rdata),
      .phase(phase), .pix(pix_data)
   );

   pxf_host_port #(
      .PIX_W(PIX_W), .PPW(PIX_PER_WORD), .WADDR_W(WADDR_W),
      .LANE_W(LANE_W), .RMW(RMW_WRITE)
   ) u_host (
      .clk(clk), .rst_n(rst_n), .slot_free(!vid_fetch), .req(host_req),
      .we(host_we), .addr(host_addr), .wdata(host_wdata),
      .mem_rdata(mem_rdata), .go(h_go), .go_we(h_we), .go_addr(h_addr),
      .go_be(h_be), .go_wdata(h_wdata), .gnt(host_gnt),
      .rvalid(host_rvalid), .rdata(host_rdata)
   );

   assign pix_valid = vid_act;
   assign mem_en    = vid_fetch || h_go;
   assign mem_we    = !vid_fetch && h_we;
   assign mem_addr  = vid_fetch ? vid_addr : h_addr;
   assign mem_be    = vid_fetch ? '0 : h_be;
   assign mem_wdata = h_wdata;
endmodule

// File: rtl/pxf_chk.sv
module pxf_chk #(
   parameter int PPW    = 4,
   parameter int LANE_W = 2,
   parameter bit RMW    = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vid_fetch,
   input logic              h_go,
   input logic              host_gnt,
   input logic              host_we,
   input logic              host_rvalid,
   input logic              mem_en,
   input logic              mem_we,
   input logic [PPW-1:0]    mem_be,
   input logic              pix_valid,
   input logic [LANE_W-1:0] phase
);
   // R6
   slot_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vid_fetch && h_go));

   // R5
   fetch_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_fetch && pix_valid) |-> (phase == LANE_W'(PPW - 2)));

   // R4
   line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pix_valid) |-> ($past(phase) == LANE_W'(PPW - 1)));

   // R9
   rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(host_gnt && !host_we));

   // R7
   lane_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && !RMW) |-> ($countones(mem_be) == 1));

   // R8
   full_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we && RMW) |-> (mem_be == '1));

   // R8
   wr_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_gnt && host_we) |-> (mem_en && mem_we));
endmodule

bind wide_pix_fetch pxf_chk #(
   .PPW(PIX_PER_WORD), .LANE_W(LANE_W), .RMW(RMW_WRITE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vid_fetch(vid_fetch), .h_go(h_go),
   .host_gnt(host_gnt), .host_we(host_we), .host_rvalid(host_rvalid),
   .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
   .pix_valid(pix_valid), .phase(phase)
);

// File: tb/tb_wide_pix_fetch.sv
`timescale 1ns/1ps
module tb_wmem (
   input  logic        clk,
   input  logic        en,
   input  logic        we,
   input  logic [3:0]  be,
   input  logic [7:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);
   logic [31:0] m [256];
   initial begin
      rdata = '0;
      for (int i = 0; i < 256; i++)
         for (int k = 0; k < 4; k++)
            m[i][k*8 +: 8] = 8'((i*4 + k) * 5 + 3);
   end
   always @(posedge clk) begin
      if (en && we) begin
         for (int k = 0; k < 4; k++)
            if (be[k]) m[addr][k*8 +: 8] <= wdata[k*8 +: 8];
      end else if (en) begin
         rdata <= m[addr];
      end
   end
endmodule

module tb_wide_pix_fetch;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n;
   logic        vid_start;
   logic [7:0]  vid_base, vid_words;
   logic        pv0, pv1;
   logic [7:0]  pd0, pd1;
   logic        h0_req, h0_we, h1_req, h1_we;
   logic [9:0]  h0_addr, h1_addr;
   logic [7:0]  h0_wd, h1_wd, h0_rd, h1_rd;
   logic        h0_gnt, h1_gnt, h0_rv, h1_rv;
   logic        m0_en, m0_we, m1_en, m1_we;
   logic [7:0]  m0_addr, m1_addr;
   logic [3:0]  m0_be, m1_be;
   logic [31:0] m0_wd, m1_wd, m0_rd, m1_rd;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] sh0 [256];
   logic [31:0] sh1 [256];

   wide_pix_fetch #(.RMW_WRITE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .vid_start(vid_start), .vid_base(vid_base),
      .vid_words(vid_words), .pix_valid(pv0), .pix_data(pd0),
      .host_req(h0_req), .host_we(h0_we), .host_addr(h0_addr),
      .host_wdata(h0_wd), .host_gnt(h0_gnt), .host_rvalid(h0_rv),
      .host_rdata(h0_rd), .mem_en(m0_en), .mem_we(m0_we),
      .mem_addr(m0_addr), .mem_be(m0_be), .mem_wdata(m0_wd),
      .mem_rdata(m0_rd)
   );
   tb_wmem mem0 (.clk(clk), .en(m0_en), .we(m0_we), .be(m0_be),
      .addr(m0_addr), .wdata(m0_wd), .rdata(m0_rd));

   wide_pix_fetch #(.RMW_WRITE(1'b1)) dut_rmw (
      .clk(clk), .rst_n(rst_n), .vid_start(vid_start), .vid_base(vid_base),
      .vid_words(vid_words), .pix_valid(pv1), .pix_data(pd1),
      .host_req(h1_req), .host_we(h1_we), .host_addr(h1_addr),
      .host_wdata(h1_wd), .host_gnt(h1_gnt), .host_rvalid(h1_rv),
      .host_rdata(h1_rd), .mem_en(m1_en), .mem_we(m1_we),
      .mem_addr(m1_addr), .mem_be(m1_be), .mem_wdata(m1_wd),
      .mem_rdata(m1_rd)
   );
   tb_wmem mem1 (.clk(clk), .en(m1_en), .we(m1_we), .be(m1_be),
      .addr(m1_addr), .wdata(m1_wd), .rdata(m1_rd));

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] sh_byte(input int p, input int a);
      return (p == 0) ? sh0[a / 4][(a % 4)*8 +: 8] : sh1[a / 4][(a % 4)*8 +: 8];
   endfunction

   task automatic host_op(input int p, input bit we, input logic [9:0] a,
                          input logic [7:0] wd, output logic [7:0] rd,
                          output int lat);
      @(negedge clk);
      if (p == 0) begin h0_req = 1; h0_we = we; h0_addr = a; h0_wd = wd; end
      else        begin h1_req = 1; h1_we = we; h1_addr = a; h1_wd = wd; end
      lat = 0;
      #1;
      while (!((p == 0) ? h0_gnt : h1_gnt)) begin
         @(negedge clk); #1; lat++;
      end
      if (we && p == 0) begin
         // R7: single lane enable, byte on that lane
         check("R7 write byte enable", {28'd0, m0_be}, 32'(4'b0001 << a[1:0]));
         check("R7 write lane data", {24'd0, m0_wd[a[1:0]*8 +: 8]}, {24'd0, wd});
         sh0[a[9:2]][a[1:0]*8 +: 8] = wd;
      end
      if (we && p == 1) begin
         // R8: full-word write carrying the merged word
         check("R8 write all enables", {28'd0, m1_be}, 32'hF);
         sh1[a[9:2]][a[1:0]*8 +: 8] = wd;
         check("R8 merged word", m1_wd, sh1[a[9:2]]);
      end
      @(negedge clk);
      if (p == 0) h0_req = 0; else h1_req = 0;
      #1;
      rd = (p == 0) ? h0_rd : h1_rd;
      if (!we) check("R9 read valid next cycle", {31'd0, (p == 0) ? h0_rv : h1_rv}, 1);
   endtask

   task automatic t_reset();
      check("R1 pix_valid", {31'd0, pv0 | pv1}, 0);
      check("R1 host_gnt", {31'd0, h0_gnt | h1_gnt}, 0);
      check("R1 host_rvalid", {31'd0, h0_rv | h1_rv}, 0);
      check("R1 mem_en", {31'd0, m0_en | m1_en}, 0);
   endtask

   task automatic run_line(input int base, input int words, input bit poke);
      int fetches = 0;
      @(negedge clk);
      vid_start = 1; vid_base = 8'(base); vid_words = 8'(words);
      #1;
      // R2: first word read in the start cycle
      check("R2 start read", {m0_en, m0_we, 22'd0, m0_addr}, {1'b1, 1'b0, 22'd0, 8'(base)});
      @(negedge clk);
      vid_start = 0;
      #1;
      check("R2 no pixel in prime cycle", {31'd0, pv0}, 0);
      for (int j = 0; j < words * 4; j++) begin
         @(negedge clk);
         vid_start = poke && (j == 5);
         if (poke && j == 5) begin vid_base = 8'd99; vid_words = 8'd3; end
         #1;
         // R3 and R4: in-order pixels, no gap
         check("R3 pixel order", {23'd0, pv0, pd0}, {23'd0, 1'b1, sh_byte(0, base*4 + j)});
         check("R3 pixel order rmw", {23'd0, pv1, pd1}, {23'd0, 1'b1, sh_byte(1, base*4 + j)});
         // R5: next word read on lane 2 only, never after the last word
         check("R5 fetch cycle", {31'd0, m0_en && !m0_we},
               {31'd0, (j % 4 == 2) && (j / 4 < words - 1)});
         if (m0_en && !m0_we) begin
            fetches++;
            check("R5 fetch address", {24'd0, m0_addr}, 32'(base + j / 4 + 1));
            // R6: no host grant in a fetch cycle
            check("R6 no grant on fetch", {31'd0, h0_gnt}, 0);
         end
         if (poke && j == 5) begin vid_base = 8'(base); vid_words = 8'(words); end
         vid_start = 0;
      end
      @(negedge clk); #1;
      check("R4 line end", {31'd0, pv0 | pv1}, 0);
      check("R5 fetch count", 32'(fetches), 32'(words - 1));
      if (poke) check("R10 start ignored mid-line", {31'd0, m0_en && !m0_we}, 0);
   endtask

   task automatic t_idle_host();
      logic [7:0] rd;
      int lat;
      host_op(0, 1, {8'd50, 2'd1}, 8'h3C, rd, lat);
      check("R7 grant latency", 32'(lat), 0);
      host_op(1, 1, {8'd50, 2'd2}, 8'hC3, rd, lat);
      check("R8 grant after read and merge", 32'(lat), 2);
      for (int k = 0; k < 4; k++) begin
         host_op(0, 0, {8'd50, 2'(k)}, 8'h00, rd, lat);
         check("R7 R9 byte readback", {24'd0, rd}, {24'd0, sh_byte(0, 200 + k)});
         host_op(1, 0, {8'd50, 2'(k)}, 8'h00, rd, lat);
         check("R8 R9 byte readback", {24'd0, rd}, {24'd0, sh_byte(1, 200 + k)});
      end
   endtask

   task automatic t_zero_words();
      @(negedge clk);
      vid_start = 1; vid_base = 8'd7; vid_words = 8'd0;
      #1;
      check("R10 zero-length start ignored", {31'd0, m0_en}, 0);
      @(negedge clk);
      vid_start = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); #1;
         check("R10 no pixels", {31'd0, pv0 | pv1}, 0);
      end
   endtask

   task automatic t_concurrent();
      fork
         run_line(10, 16, 1'b0);
         begin
            logic [7:0] rd;
            int lat;
            for (int i = 0; i < 8; i++)
               host_op(0, 1, 10'(800 + i), 8'(8'h90 + i), rd, lat);
         end
         begin
            logic [7:0] rd;
            int lat;
            for (int i = 0; i < 8; i++)
               host_op(1, 1, 10'(800 + i), 8'(8'h60 + i), rd, lat);
         end
      join
      for (int i = 0; i < 8; i++) begin
         logic [7:0] rd;
         int lat;
         host_op(0, 0, 10'(800 + i), 8'h00, rd, lat);
         check("R7 write under video", {24'd0, rd}, {24'd0, sh_byte(0, 800 + i)});
         host_op(1, 0, 10'(800 + i), 8'h00, rd, lat);
         check("R8 write under video", {24'd0, rd}, {24'd0, sh_byte(1, 800 + i)});
      end
   endtask

   bit done = 0;

   initial begin
      for (int i = 0; i < 256; i++)
         for (int k = 0; k < 4; k++) begin
            sh0[i][k*8 +: 8] = 8'((i*4 + k) * 5 + 3);
            sh1[i][k*8 +: 8] = 8'((i*4 + k) * 5 + 3);
         end
      rst_n = 0; vid_start = 0; vid_base = 0; vid_words = 0;
      h0_req = 0; h0_we = 0; h0_addr = 0; h0_wd = 0;
      h1_req = 0; h1_we = 0; h1_addr = 0; h1_wd = 0;
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1;
      #1;
      t_reset();
      run_line(3, 3, 1'b0);
      t_idle_host();
      run_line(40, 2, 1'b1);
      t_zero_words();
      t_concurrent();
      run_line(250, 1, 1'b0);
      repeat (4) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule